// File: doc/BRIEF.md
# Universal Registered Bus Transceiver

This block moves 18-bit words in both directions between an A port and a B port. Each direction has its own data path and its own four controls: an active-low capture enable, a latch control, a load strobe and an active-low output enable. A path can pass its input straight through, freeze the last value it passed, or load its input on a rising edge of its strobe. The two directions share no state.

The B side models an open-drain wired-OR driver: next to the data word it gives one pull-down enable per bit, and only zeros pull the line. The A side models a three-state driver: a data word plus one enable. The controls are sampled on the block clock, so the load strobe is a level signal whose rising edge the block detects itself. The reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `univ_bus_xcvr`

## Requirements
- R1: While a direction's output enable (`*_oe_n`) is 1, that direction drives nothing: `b_pd` is all zeros for A-to-B and `a_oe` is 0 for B-to-A. While it is 0, `a_oe` is 1.
- R2: While a direction's latch control (`*_le`) is 1, its output word equals its current input word in the same cycle, whatever its capture enable and strobe are.
- R3: While the capture enable (`*_ce_n`) is 0 and the latch control is 1, the stored word takes the input at every clock edge. After the latch control falls, the output shows the input from the last cycle in which the latch control was 1.
- R4: With capture enable 0 and latch control 0, the stored word loads the input at a clock edge where the strobe is 1 and was 0 at the edge before. At any other edge it keeps its value. A strobe held high loads only once.
- R5: While the capture enable is 1, the stored word never changes. Strobe edges are ignored, and a transparent phase with capture enable 1 leaves the old stored word, which shows again when the latch control returns to 0.
- R6: `b_out` carries the A-to-B path word. `b_pd[i]` is 1 exactly when the A-to-B output enable is 0 and bit i of that word is 0.
- R7: A low `rst_n` clears the stored word of both directions to zero at once, without waiting for a clock edge. Release takes effect after two clock edges.
- R8: The two directions are independent. Loading, latching or driving one path never changes the other path's stored word, and this holds with both output enables active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | 18 | Word arriving on the A port (A-to-B source) |
| ab_ce_n | input | 1 | A-to-B capture enable, active low |
| ab_le | input | 1 | A-to-B latch control, 1 = pass-through |
| ab_strb | input | 1 | A-to-B load strobe, acts on its rising edge |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| b_in | input | 18 | Word arriving on the B port (B-to-A source) |
| ba_ce_n | input | 1 | B-to-A capture enable, active low |
| ba_le | input | 1 | B-to-A latch control, 1 = pass-through |
| ba_strb | input | 1 | B-to-A load strobe, acts on its rising edge |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | A-to-B path word toward the B port |
| b_pd | output | 18 | Per-bit pull-down enable of the open-drain B driver |
| a_out | output | 18 | B-to-A path word toward the A port |
| a_oe | output | 1 | Enable of the three-state A driver |

## Verification
The assertions check on every cycle that stored words move only as the capture rules allow: they track in pass-through, load on a detected strobe rise, and stay frozen under a disabled capture enable or an idle strobe. They also check that a disabled output never pulls the B bus and that pass-through pulls exactly the zero bits of the live A word. The end-to-end sequences can be shown only by the bench's scenarios: the word frozen by a falling latch control, the stale word that returns after a transparent phase with capture disabled, a single load from a strobe held high, the asynchronous clear in mid-run, and two paths loaded and latched together without one disturbing the other.

// File: rtl/ubx_pkg.sv
package ubx_pkg;

  localparam int unsigned UBX_WIDTH = 18;

  // Per-direction control bundle, all levels sampled on clk.
  typedef struct packed {
    logic ce_n;
    logic le;
    logic strb;
    logic oe_n;
  } dir_ctrl_t;

endpackage

// File: rtl/ubx_rst_sync.sv
module ubx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ubx_path.sv
module ubx_path
  import ubx_pkg::*;
#(
  parameter int unsigned WIDTH = UBX_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dir_ctrl_t        ctrl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] store_q;
  logic [WIDTH-1:0] store_d;
  logic             strb_q;
  logic             strb_d;
  logic             strb_rise;
  logic             load_en;

  // Next-state: capture when enabled and either passing through or strobed.
  always_comb begin
    strb_rise = ctrl.strb & ~strb_q;
    load_en   = ~ctrl.ce_n & (ctrl.le | strb_rise);
    store_d   = din;
    strb_d    = ctrl.strb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      strb_q  <= 1'b0;
    end else begin
      strb_q <= strb_d;
      if (load_en) begin
        store_q <= store_d;
      end
    end
  end

  // Pass-through bypass around the storage.
  always_comb begin
    dout = ctrl.le ? din : store_q;
  end

  // R3: capture enabled in pass-through -> storage follows the input.
  p_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.ce_n && ctrl.le) |=> (store_q == $past(din)));

  // R4: strobe rise with capture enabled and latch closed -> load.
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.ce_n && !ctrl.le && ctrl.strb && !$past(ctrl.strb)) |=> (store_q == $past(din)));

  // R4: latch closed and strobe not rising -> storage keeps its value.
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.le && !(ctrl.strb && !$past(ctrl.strb))) |=> $stable(store_q));

  // R5: capture disabled -> storage frozen.
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ce_n |=> $stable(store_q));

endmodule

// File: rtl/ubx_od_drv.sv
module ubx_od_drv #(
  parameter int unsigned WIDTH = 18
) (
  input  logic             oe_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] pd
);

  // Each bit pulls its line only for a driven zero; a one releases it.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pd[i] = ~oe_n & ~d[i];
    assign q[i]  = d[i];
  end

endmodule

// File: rtl/univ_bus_xcvr.sv
module univ_bus_xcvr
  import ubx_pkg::*;
#(
  parameter int unsigned WIDTH = UBX_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic             ab_ce_n,
  input  logic             ab_le,
  input  logic             ab_strb,
  input  logic             ab_oe_n,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ba_ce_n,
  input  logic             ba_le,
  input  logic             ba_strb,
  input  logic             ba_oe_n,
  output logic [WIDTH-1:0] b_out,
  output logic [WIDTH-1:0] b_pd,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe
);

  logic             rst_sync_n;
  dir_ctrl_t        ctrl_ab;
  dir_ctrl_t        ctrl_ba;
  logic [WIDTH-1:0] word_ab;
  logic [WIDTH-1:0] word_ba;

  always_comb begin
    ctrl_ab = '{ce_n: ab_ce_n, le: ab_le, strb: ab_strb, oe_n: ab_oe_n};
    ctrl_ba = '{ce_n: ba_ce_n, le: ba_le, strb: ba_strb, oe_n: ba_oe_n};
  end

  ubx_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ubx_path #(.WIDTH(WIDTH)) i_path_ab (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ctrl  (ctrl_ab),
    .din   (a_in),
    .dout  (word_ab)
  );

  ubx_path #(.WIDTH(WIDTH)) i_path_ba (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ctrl  (ctrl_ba),
    .din   (b_in),
    .dout  (word_ba)
  );

  ubx_od_drv #(.WIDTH(WIDTH)) i_od_b (
    .oe_n (ab_oe_n),
    .d    (word_ab),
    .q    (b_out),
    .pd   (b_pd)
  );

  // Three-state A driver: data word plus one enable.
  always_comb begin
    a_out = word_ba;
    a_oe  = ~ba_oe_n;
  end

  // R1: a disabled B side never pulls the bus.
  p_hiz_b_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ab_oe_n |-> (b_pd == '0));

  // R2 / R6: in pass-through with output on, the pulled bits are the zeros of the live A word.
  p_pass_pd_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ab_le && !ab_oe_n) |-> (b_pd == ~a_in));

  // R6: a pulled bit is always a zero data bit.
  p_pd_zero_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((b_pd & b_out) == '0));

endmodule

// File: tb/test_univ_bus_xcvr.sv
`timescale 1ns/1ps
module test_univ_bus_xcvr;

  localparam int W     = 18;
  localparam int NVEC  = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic         ab_ce_n, ab_le, ab_strb, ab_oe_n;
  logic         ba_ce_n, ba_le, ba_strb, ba_oe_n;
  logic [W-1:0] b_out, b_pd, a_out;
  logic         a_oe;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  univ_bus_xcvr #(.WIDTH(W)) i_univ_bus_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .ab_ce_n(ab_ce_n), .ab_le(ab_le), .ab_strb(ab_strb), .ab_oe_n(ab_oe_n),
    .b_in(b_in), .ba_ce_n(ba_ce_n), .ba_le(ba_le), .ba_strb(ba_strb), .ba_oe_n(ba_oe_n),
    .b_out(b_out), .b_pd(b_pd), .a_out(a_out), .a_oe(a_oe)
  );

  // {ce_n, le, strb, oe_n, a_in, expected b_out, expected b_pd}
  localparam logic [57:0] VECS [NVEC] = '{
    {4'b1001, 18'h12345, 18'h00000, 18'h00000}, // R7 R1 reset value, output off
    {4'b1000, 18'h12345, 18'h00000, 18'h3FFFF}, // R6 zero word pulls all bits
    {4'b0100, 18'h0ABCD, 18'h0ABCD, 18'h35432}, // R2 pass-through
    {4'b0100, 18'h2F0F0, 18'h2F0F0, 18'h10F0F}, // R2 R3 pass-through, tracking
    {4'b0000, 18'h11111, 18'h2F0F0, 18'h10F0F}, // R3 frozen at latch fall
    {4'b0010, 18'h11111, 18'h11111, 18'h2EEEE}, // R4 strobe rise loads
    {4'b0010, 18'h22222, 18'h11111, 18'h2EEEE}, // R4 strobe held, no reload
    {4'b0000, 18'h22222, 18'h11111, 18'h2EEEE}, // R4 strobe low, hold
    {4'b1010, 18'h33333, 18'h11111, 18'h2EEEE}, // R5 rise inhibited
    {4'b1000, 18'h33333, 18'h11111, 18'h2EEEE}, // R5 hold
    {4'b1100, 18'h33333, 18'h33333, 18'h0CCCC}, // R2 R5 pass-through, ce off
    {4'b1000, 18'h33333, 18'h11111, 18'h2EEEE}, // R5 old word returns
    {4'b0011, 18'h3FFFF, 18'h3FFFF, 18'h00000}, // R4 R1 load with output off
    {4'b0000, 18'h00000, 18'h3FFFF, 18'h00000}, // R6 all ones release
    {4'b0110, 18'h00000, 18'h00000, 18'h3FFFF}, // R2 strobe ignored in pass-through
    {4'b0000, 18'h15555, 18'h00000, 18'h3FFFF}  // R3 held after pass-through
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    a_in = '0; b_in = '0;
    {ab_ce_n, ab_le, ab_strb, ab_oe_n} = 4'b1001;
    {ba_ce_n, ba_le, ba_strb, ba_oe_n} = 4'b1001;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 a_out after reset", a_out, '0);
    chk("R1 a_oe off", {17'd0, a_oe}, '0);

    // Table walk on the A-to-B path.
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {ab_ce_n, ab_le, ab_strb, ab_oe_n} = VECS[v][57:54];
      a_in = VECS[v][53:36];
      @(posedge clk);
      #1;
      chk($sformatf("vec%0d b_out", v), b_out, VECS[v][35:18]);
      chk($sformatf("vec%0d b_pd", v), b_pd, VECS[v][17:0]);
    end

    // R8: both paths loaded together, both outputs enabled.
    @(negedge clk);
    {ab_ce_n, ab_le, ab_strb, ab_oe_n} = 4'b0000;
    {ba_ce_n, ba_le, ba_strb, ba_oe_n} = 4'b0000;
    a_in = 18'h0AAAA; b_in = 18'h15555;
    @(posedge clk); #1;
    @(negedge clk);
    ab_strb = 1'b1; ba_strb = 1'b1;
    @(posedge clk); #1;
    chk("R8 a_out loaded", a_out, 18'h15555);
    chk("R8 b_out loaded", b_out, 18'h0AAAA);
    chk("R1 a_oe on", {17'd0, a_oe}, 18'd1);

    // R8 R2: B-to-A pass-through while A-to-B holds.
    @(negedge clk);
    ab_strb = 1'b0; ba_strb = 1'b0;
    a_in = 18'h00001; b_in = 18'h3C3C3; ba_le = 1'b1;
    @(posedge clk); #1;
    chk("R2 a_out pass-through", a_out, 18'h3C3C3);
    chk("R8 b_out untouched", b_out, 18'h0AAAA);

    // R3: latch fall on B-to-A freezes the last passed word.
    @(negedge clk);
    ba_le = 1'b0; b_in = 18'h00007;
    @(posedge clk); #1;
    chk("R3 a_out frozen", a_out, 18'h3C3C3);
    chk("R8 b_out still untouched", b_out, 18'h0AAAA);

    // R1: B-to-A output disable.
    @(negedge clk);
    ba_oe_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 a_oe off again", {17'd0, a_oe}, '0);

    // R7: asynchronous clear in mid-run, no clock edge needed.
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R7 a_out async clear", a_out, '0);
    chk("R7 b_out async clear", b_out, '0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R7 b_out after release", b_out, '0);

    finish_run();
  end

endmodule